// File: doc/BRIEF.md
# Register Initialization Sequencer

This block brings a peripheral's control registers to a known state without software. It holds an initialization table of packed entries and starts walking it, from entry zero, as soon as reset is released. For each entry it pulls out a register address and a 16-bit value and sends them as one write frame on a four-wire serial register port. It waits until that frame and the idle gap after it have finished before it reads the next entry.

The walk does not end when the table runs out. It ends when the address field of an entry equals a designated final register address (default 0x1F). Once that frame has gone out, the block halts and raises a done flag. If the last table slot is sent and no entry carried the final address, the block halts and raises an error flag instead. A start pulse, accepted only while the block is halted, runs the whole sequence again from entry zero.

The table contents are a parameter. The serial clock rate is the system clock divided by a parameter.

Top module: `reg_init_seq`

## Requirements
- R1: A table entry is 32 bits wide. Bits [23:16] hold the register address and bits [15:0] hold the register data. Bits [31:24] are ignored.
- R2: Each write frame is 24 bits long and sent MSB first on mosi_o: a zero write bit, then address bits [6:0], then the 16 data bits. cs_n_o is low for the whole frame. sclk_o is high only inside a frame. mosi_o changes only while sclk_o is low, and the receiver samples it on the rising edge of sclk_o.
- R3: Within a frame, sclk_o has a period of CLK_DIV system clocks. It is low for the first half of each period and high for the second half, so consecutive rising edges are exactly CLK_DIV cycles apart.
- R4: Between two frames, cs_n_o stays high for at least CLK_DIV system clocks.
- R5: After reset is released, entries are sent in index order starting at index 0. Each entry produces exactly one frame, and a frame does not start until the previous one has finished.
- R6: The sequence stops after the frame of the first entry whose full 8-bit address equals LAST_ADDR. No further frame is sent and done_o rises. An address that matches only in its low 7 bits does not stop the sequence.
- R7: Once high, done_o stays high until reset or until a start pulse is accepted.
- R8: If the entry at index ROM_DEPTH-1 has been sent and no entry has matched LAST_ADDR, error_o rises, no further frame is sent and done_o stays low.
- R9: A start_i pulse while halted (done or error) clears the flag and reruns the sequence from index 0. A start_i pulse while the sequence is running has no effect.
- R10: done_o and error_o are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Rerun request, accepted only while halted |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | 1 | Frame select, active low |
| mosi_o | output | 1 | Serial write data |
| done_o | output | 1 | Sequence ended on the final address |
| error_o | output | 1 | Table exhausted without the final address |

## Verification
Two cases are hard to reach from the ports. The first is the error ending, which needs a full table with no final address. The second is a near-miss address such as 0x9F, whose low seven bits look like the final address on the wire. A second instance is built with a table of that kind, so it must send all 64 frames and end in error. A start pulse given in the middle of a rerun checks the ignore rule: the frame stream must show exactly one clean second pass with no truncated frame.

// File: rtl/reg_init_pkg.sv
package reg_init_pkg;
  localparam int unsigned ENTRY_W  = 32;
  localparam int unsigned RADDR_W  = 8;
  localparam int unsigned RDATA_W  = 16;
  localparam int unsigned FRAME_W  = 1 + (RADDR_W - 1) + RDATA_W;
  localparam int unsigned DEF_DEPTH = 64;

  typedef struct packed {
    logic [ENTRY_W-RADDR_W-RDATA_W-1:0] rsvd;
    logic [RADDR_W-1:0]                 addr;
    logic [RDATA_W-1:0]                 data;
  } entry_t;

  typedef enum logic [2:0] {
    CS_FETCH, CS_SEND, CS_WAIT, CS_DONE, CS_ERR
  } ctrl_state_e;

  typedef enum logic [1:0] {
    TX_IDLE, TX_SHIFT, TX_GAP
  } tx_state_e;

  // Default table: sequential addresses, final address at index 0x1F.
  function automatic logic [DEF_DEPTH*ENTRY_W-1:0] default_table();
    logic [DEF_DEPTH*ENTRY_W-1:0] t;
    t = '0;
    for (int i = 0; i < int'(DEF_DEPTH); i++) begin
      t[i*ENTRY_W +: ENTRY_W] = {8'h00, 8'(i), 16'(i * 16'h0101)};
    end
    return t;
  endfunction
endpackage

// File: rtl/init_table.sv
module init_table #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 32,
  parameter logic [DEPTH*WIDTH-1:0] CONTENT = '0,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_word
    assign mem[g] = CONTENT[g*WIDTH +: WIDTH];
  end

  // one-cycle registered read
  always_ff @(posedge clk_i) begin
    data_o <= mem[idx_i];
  end
endmodule

// File: rtl/init_spi_tx.sv
module init_spi_tx
  import reg_init_pkg::*;
#(
  parameter int unsigned CLK_DIV = 8,
  parameter int unsigned WORD_W  = 24,
  localparam int unsigned HALF   = CLK_DIV / 2,
  localparam int unsigned DIV_W  = $clog2(CLK_DIV),
  localparam int unsigned BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              done_o,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o
);
  tx_state_e         state_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WORD_W-1:0] sh_q;
  logic              div_end;

  assign div_end = (div_q == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          if (start_i) begin
            sh_q    <= word_i;
            div_q   <= '0;
            bit_q   <= '0;
            state_q <= TX_SHIFT;
          end
        end
        TX_SHIFT: begin
          if (div_end) begin
            div_q <= '0;
            if (bit_q == BIT_W'(WORD_W - 1)) begin
              state_q <= TX_GAP;
            end else begin
              bit_q <= bit_q + 1'b1;
              sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        TX_GAP: begin
          if (div_end) begin
            div_q   <= '0;
            state_q <= TX_IDLE;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign done_o = (state_q == TX_GAP) && div_end;
  assign cs_n_o = (state_q != TX_SHIFT);
  assign sclk_o = (state_q == TX_SHIFT) && (div_q >= DIV_W'(HALF));
  assign mosi_o = (state_q == TX_SHIFT) && sh_q[WORD_W-1];
endmodule

// File: rtl/init_ctrl.sv
module init_ctrl
  import reg_init_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter logic [RADDR_W-1:0] LAST_ADDR = 8'h1F,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic [IDX_W-1:0]   idx_o,
  input  logic [ENTRY_W-1:0] entry_i,
  output logic               tx_start_o,
  output logic [FRAME_W-1:0] tx_word_o,
  input  logic               tx_done_i,
  output logic               done_o,
  output logic               error_o
);
  ctrl_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_q;
  entry_t           ent;

  assign ent = entry_t'(entry_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CS_FETCH;
      idx_q   <= '0;
      last_q  <= 1'b0;
    end else begin
      unique case (state_q)
        CS_FETCH: state_q <= CS_SEND;
        CS_SEND: begin
          last_q  <= (ent.addr == LAST_ADDR);
          state_q <= CS_WAIT;
        end
        CS_WAIT: begin
          if (tx_done_i) begin
            if (last_q) begin
              state_q <= CS_DONE;
            end else if (idx_q == IDX_W'(DEPTH - 1)) begin
              state_q <= CS_ERR;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= CS_FETCH;
            end
          end
        end
        CS_DONE, CS_ERR: begin
          if (start_i) begin
            idx_q   <= '0;
            state_q <= CS_FETCH;
          end
        end
        default: state_q <= CS_FETCH;
      endcase
    end
  end

  assign idx_o      = idx_q;
  assign tx_start_o = (state_q == CS_SEND);
  assign tx_word_o  = {1'b0, ent.addr[RADDR_W-2:0], ent.data};
  assign done_o     = (state_q == CS_DONE);
  assign error_o    = (state_q == CS_ERR);
endmodule

// File: rtl/reg_init_seq.sv
module reg_init_seq
  import reg_init_pkg::*;
#(
  parameter int unsigned ROM_DEPTH = DEF_DEPTH,
  parameter int unsigned CLK_DIV   = 8,
  parameter logic [RADDR_W-1:0] LAST_ADDR = 8'h1F,
  parameter logic [ROM_DEPTH*ENTRY_W-1:0] ROM_INIT = default_table(),
  localparam int unsigned IDX_W = $clog2(ROM_DEPTH)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic sclk_o,
  output logic cs_n_o,
  output logic mosi_o,
  output logic done_o,
  output logic error_o
);
  logic [IDX_W-1:0]   idx;
  logic [ENTRY_W-1:0] entry;
  logic               tx_start;
  logic [FRAME_W-1:0] tx_word;
  logic               tx_done;

  init_table #(
    .DEPTH  (ROM_DEPTH),
    .WIDTH  (ENTRY_W),
    .CONTENT(ROM_INIT)
  ) u_table (
    .clk_i (clk_i),
    .idx_i (idx),
    .data_o(entry)
  );

  init_ctrl #(
    .DEPTH    (ROM_DEPTH),
    .LAST_ADDR(LAST_ADDR)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .idx_o     (idx),
    .entry_i   (entry),
    .tx_start_o(tx_start),
    .tx_word_o (tx_word),
    .tx_done_i (tx_done),
    .done_o    (done_o),
    .error_o   (error_o)
  );

  init_spi_tx #(
    .CLK_DIV(CLK_DIV),
    .WORD_W (FRAME_W)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tx_start),
    .word_i (tx_word),
    .done_o (tx_done),
    .sclk_o (sclk_o),
    .cs_n_o (cs_n_o),
    .mosi_o (mosi_o)
  );
endmodule

// File: rtl/reg_init_seq_chk.sv
module reg_init_seq_chk #(
  parameter int unsigned CLK_DIV = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic sclk_o,
  input logic cs_n_o,
  input logic mosi_o,
  input logic done_o,
  input logic error_o
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= 16'hFFFF;
    end else if (!cs_n_o) begin
      hi_cnt <= '0;
    end else if (hi_cnt != 16'hFFFF) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o)); // R10

  AST_SCLK_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_n_o); // R2

  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R2

  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> (hi_cnt >= 16'(CLK_DIV))); // R4

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R7

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !start_i) |=> error_o); // R8

  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || error_o) |-> cs_n_o); // R6
endmodule

bind reg_init_seq reg_init_seq_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .sclk_o (sclk_o),
  .cs_n_o (cs_n_o),
  .mosi_o (mosi_o),
  .done_o (done_o),
  .error_o(error_o)
);

// File: tb/reg_init_seq_bench.sv
module spi_frame_mon #(
  parameter int DIV = 8
) (
  input logic clk,
  input logic sclk,
  input logic cs_n,
  input logic mosi
);
  logic [23:0] frames [128];
  int n_frames = 0;
  int bad_period = 0, bad_gap = 0, bad_len = 0, bad_mosi = 0;
  int cyc = 0, last_rise = 0, bits = 0, gap_cnt = 1000;
  logic [23:0] sh = '0;
  logic p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!cs_n && p_cs) begin
      if (gap_cnt < DIV) bad_gap++;
      bits = 0;
      sh = '0;
    end
    if (!cs_n && sclk && p_sclk && (mosi != p_mosi)) bad_mosi++;
    if (sclk && !p_sclk) begin
      sh = {sh[22:0], mosi};
      if (bits > 0 && (cyc - last_rise) != DIV) bad_period++;
      last_rise = cyc;
      bits++;
    end
    if (cs_n && !p_cs) begin
      if (bits != 24) bad_len++;
      if (n_frames < 128) frames[n_frames] = sh;
      n_frames++;
    end
    gap_cnt = cs_n ? gap_cnt + 1 : 0;
    p_sclk = sclk;
    p_cs = cs_n;
    p_mosi = mosi;
  end
endmodule

module reg_init_seq_bench;
  localparam int DEPTH = 64;
  localparam int DIV = 8;

  function automatic logic [15:0] dval(int i);
    return 16'h5A00 + 16'(i * 16'h0111);
  endfunction

  // good: sequential addresses, final address 0x1F at index 31, junk top byte
  function automatic logic [DEPTH*32-1:0] good_tbl();
    logic [DEPTH*32-1:0] t;
    for (int i = 0; i < DEPTH; i++)
      t[i*32 +: 32] = {8'hC3 ^ 8'(i), 8'(i), dval(i)};
    return t;
  endfunction

  // no final address; index 5 carries 0x9F (low 7 bits look like 0x1F)
  function automatic logic [7:0] err_addr(int i);
    return (i == 5) ? 8'h9F : 8'h40 + 8'(i);
  endfunction

  function automatic logic [DEPTH*32-1:0] err_tbl();
    logic [DEPTH*32-1:0] t;
    for (int i = 0; i < DEPTH; i++)
      t[i*32 +: 32] = {8'h00, err_addr(i), dval(i)};
    return t;
  endfunction

  localparam logic [DEPTH*32-1:0] GOOD = good_tbl();
  localparam logic [DEPTH*32-1:0] BAD  = err_tbl();

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic sclk_a, cs_a, mosi_a, done_a, err_a;
  logic sclk_b, cs_b, mosi_b, done_b, err_b;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  reg_init_seq #(.ROM_DEPTH(DEPTH), .CLK_DIV(DIV), .LAST_ADDR(8'h1F), .ROM_INIT(GOOD))
    u_reg_init_seq (.clk_i(clk), .rst_ni(rst_n), .start_i(start), .sclk_o(sclk_a),
      .cs_n_o(cs_a), .mosi_o(mosi_a), .done_o(done_a), .error_o(err_a));

  reg_init_seq #(.ROM_DEPTH(DEPTH), .CLK_DIV(DIV), .LAST_ADDR(8'h1F), .ROM_INIT(BAD))
    u_reg_init_seq_err (.clk_i(clk), .rst_ni(rst_n), .start_i(1'b0), .sclk_o(sclk_b),
      .cs_n_o(cs_b), .mosi_o(mosi_b), .done_o(done_b), .error_o(err_b));

  spi_frame_mon #(.DIV(DIV)) u_mon_a (.clk(clk), .sclk(sclk_a), .cs_n(cs_a), .mosi(mosi_a));
  spi_frame_mon #(.DIV(DIV)) u_mon_b (.clk(clk), .sclk(sclk_b), .cs_n(cs_b), .mosi(mosi_b));

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_flag(ref logic f, input int lim);
    for (int k = 0; k < lim && !f; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5", "cs_n in reset", cs_a, 1);
    chk("R2", "sclk in reset", sclk_a, 0);
    chk("R7", "done in reset", done_a, 0);
    chk("R10", "error in reset", err_a, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_normal();
    wait_flag(done_a, 20000);
    chk("R6", "done after final addr", done_a, 1);
    chk("R10", "error with done", err_a, 0);
    chk("R6", "frame count", u_mon_a.n_frames, 32);
    for (int i = 0; i < 32; i++)
      chk("R1", $sformatf("frame %0d", i), u_mon_a.frames[i], {1'b0, 7'(i), dval(i)});
    repeat (600) @(negedge clk);
    chk("R6", "no frame after done", u_mon_a.n_frames, 32);
    chk("R7", "done held", done_a, 1);
    chk("R3", "sclk period", u_mon_a.bad_period, 0);
    chk("R4", "cs gap", u_mon_a.bad_gap, 0);
    chk("R2", "frame length", u_mon_a.bad_len, 0);
    chk("R2", "mosi stable sclk high", u_mon_a.bad_mosi, 0);
  endtask

  task automatic t_error();
    wait_flag(err_b, 40000);
    chk("R8", "error raised", err_b, 1);
    chk("R8", "done low on error", done_b, 0);
    chk("R8", "frame count", u_mon_b.n_frames, DEPTH);
    chk("R6", "near-miss frame 5", u_mon_b.frames[5], {1'b0, 7'h1F, dval(5)});
    chk("R5", "last frame", u_mon_b.frames[DEPTH-1], {1'b0, 7'(err_addr(DEPTH-1)), dval(DEPTH-1)});
    repeat (600) @(negedge clk);
    chk("R8", "no frame after error", u_mon_b.n_frames, DEPTH);
    chk("R2", "frame length err inst", u_mon_b.bad_len, 0);
  endtask

  task automatic t_restart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R9", "done cleared by start", done_a, 0);
    for (int k = 0; k < 20000 && u_mon_a.n_frames < 42; k++) @(negedge clk);
    start = 1'b1;  // must be ignored: sequence running
    @(negedge clk);
    start = 1'b0;
    wait_flag(done_a, 20000);
    chk("R9", "done after rerun", done_a, 1);
    repeat (600) @(negedge clk);
    chk("R9", "rerun frame total", u_mon_a.n_frames, 64);
    for (int i = 0; i < 32; i++)
      chk("R9", $sformatf("rerun frame %0d", i), u_mon_a.frames[32+i], {1'b0, 7'(i), dval(i)});
    chk("R2", "no truncated frame", u_mon_a.bad_len, 0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_error();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R5 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule